// File: doc/BRIEF.md
# Watchdog Timer with Feed Lock

This block supervises software by counting down from a programmed timeout. The count steps once every few clock cycles, on a tick from a fixed internal prescaler. Software keeps the system alive by writing a two-value key sequence to a feed register, which reloads the count. If the count runs out, or software writes the key sequence wrongly, the block raises a fault. A mode bit picks whether the fault requests a system reset or only raises an interrupt.

Software can switch the watchdog on but cannot switch it off. Supervision starts with the first correct feed after the enable is set. A sticky flag records that a fault happened. A reset of the block's logic leaves this flag intact, so software can see after the restart that the watchdog caused it. Only a power-on reset or a software write clears the flag. While a debugger holds the debug-stall input high, the count and the prescaler stand still.

The register bus uses a 2-bit word address:

| Address | Register |
|---|---|
| 0 | Control. Bit 0 is the enable, bit 1 the mode (1 = reset), bit 2 the fault flag, bit 3 the active state. |
| 1 | Timeout constant |
| 2 | Feed (write only) |
| 3 | Current count (read only) |

Top module: `wdt_guard`

## Requirements
- R1: Once active, the block faults exactly PRESCALE*T clock edges after the edge that accepted the last valid feed, where T is the timeout constant. The fault is visible on the outputs right after that edge.
- R2: Writing a value below MIN_TMO to address 1 stores MIN_TMO; any other value is stored as written. Reading address 1 returns the stored constant.
- R3: Writing 1 to control bit 0 sets the enable. Writing 0 to it has no effect. Only a fault, `rst` or `por` clears the enable.
- R4: After the enable is set, the count does not move and no timeout fault occurs until the first valid feed. Reading control bit 3 returns 1 once the block is active.
- R5: A valid feed is a write of 0xAA to address 2 followed, with no other bus access in between, by a write of 0x55 to address 2. Only the low 8 bits of the data are compared, and idle cycles between the two writes are allowed. A valid feed loads the count from the constant and restarts the prescaler.
- R6: While enabled, three cases are a fault: any feed-register write that is not 0xAA as the first write of the sequence; any access other than the 0x55 write directly after 0xAA; and a timeout. While disabled, the same writes have no effect.
- R7: Control bit 1 selects the fault action: 0 raises `irq`, 1 raises `rst_req`. The bit is writable only while the enable is clear.
- R8: A fault sets control bit 2. Writing 0 to bit 2 clears the flag and `irq`. `rst` keeps the flag; `por` clears it.
- R9: `rst_req` stays high from a fault until `rst` or `por`.
- R10: While `dbg_stall` is high, the count holds its value and no timeout fault occurs.
- R11: After `por`, both outputs are low, control reads 0, and the constant and the count both read MIN_TMO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por | input | 1 | Power-on reset, synchronous, active high, clears everything |
| rst | input | 1 | Logic reset, synchronous, active high, keeps the fault flag |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, registered, valid the cycle after a read |
| dbg_stall | input | 1 | Debug halt: freezes the count |
| rst_req | output | 1 | System reset request |
| irq | output | 1 | Watchdog interrupt |

## Verification
The bench keeps the 32-bit count and the prescale factor of 4, but lowers MIN_TMO to 16. That brings the shortest timeout down to 64 clock edges, so the bench can hit the exact fault edge and the clamp boundary around 16 many times within the run. Wider timeouts up to the full 32-bit constant are only written and read back, not counted out.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_TC   = 2'd1,
    REG_FEED = 2'd2,
    REG_CNT  = 2'd3
  } wdt_reg_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_KEY1 = 1'b1
  } feed_state_e;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  localparam int CB_EN     = 0;
  localparam int CB_MODE   = 1;
  localparam int CB_FLAG   = 2;
  localparam int CB_ACTIVE = 3;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hold,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_nodiv
      assign tick = !hold;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pre_q <= '0;
        end else if (!hold) begin
          pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
      end

      assign tick = !hold && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt_feed_chk.sv
module wdt_feed_chk
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc,
  input  logic       wr,
  input  logic       is_feed,
  input  logic [7:0] wdata,
  output logic       feed_ok,
  output logic       feed_bad
);
  feed_state_e st_q, st_d;

  always_comb begin
    st_d     = st_q;
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    if (acc) begin
      unique case (st_q)
        FS_IDLE: begin
          if (wr && is_feed) begin
            if (wdata == FEED_KEY1) st_d = FS_KEY1;
            else                    feed_bad = 1'b1;
          end
        end
        FS_KEY1: begin
          st_d = FS_IDLE;
          if (wr && is_feed && wdata == FEED_KEY2) feed_ok = 1'b1;
          else                                     feed_bad = 1'b1;
        end
        default: st_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= FS_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int          W       = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= RST_VAL;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 4,
  parameter int MIN_TMO  = 256
) (
  input  logic              clk,
  input  logic              por,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              dbg_stall,
  output logic              rst_req,
  output logic              irq
);
  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(MIN_TMO);

  logic any_rst;
  logic wr_ctrl, wr_tc, rd_acc;
  logic en_q, mode_q, armed_q, flag_q, irq_q, rreq_q;
  logic [CNT_W-1:0] tc_q, cnt, rdata_q;
  logic tick, last, feed_ok, feed_bad, expire, fault;

  assign any_rst = por || rst;
  assign wr_ctrl = bus_sel && bus_wr && (bus_addr == REG_CTRL);
  assign wr_tc   = bus_sel && bus_wr && (bus_addr == REG_TC);
  assign rd_acc  = bus_sel && !bus_wr;

  wdt_feed_chk u_feed (
    .clk     (clk),
    .rst     (any_rst),
    .acc     (bus_sel),
    .wr      (bus_wr),
    .is_feed (bus_addr == REG_FEED),
    .wdata   (bus_wdata[7:0]),
    .feed_ok (feed_ok),
    .feed_bad(feed_bad)
  );

  wdt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk (clk),
    .rst (any_rst),
    .clr (feed_ok),
    .hold(dbg_stall || !armed_q),
    .tick(tick)
  );

  wdt_down_cnt #(.W(CNT_W), .RST_VAL(TC_FLOOR)) u_cnt (
    .clk     (clk),
    .rst     (any_rst),
    .load    (feed_ok),
    .load_val(tc_q),
    .dec     (armed_q && tick),
    .cnt     (cnt),
    .last    (last)
  );

  assign expire = armed_q && tick && last && !feed_ok;
  assign fault  = en_q && (feed_bad || expire);

  always_ff @(posedge clk) begin
    if (any_rst) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      rreq_q  <= 1'b0;
      tc_q    <= TC_FLOOR;
    end else begin
      if (fault)                             en_q <= 1'b0;
      else if (wr_ctrl && bus_wdata[CB_EN])  en_q <= 1'b1;

      if (wr_ctrl && !en_q) mode_q <= bus_wdata[CB_MODE];

      if (fault)                 armed_q <= 1'b0;
      else if (feed_ok && en_q)  armed_q <= 1'b1;

      if (fault && !mode_q)                     irq_q <= 1'b1;
      else if (wr_ctrl && !bus_wdata[CB_FLAG])  irq_q <= 1'b0;

      if (fault && mode_q) rreq_q <= 1'b1;

      if (wr_tc) tc_q <= (bus_wdata < TC_FLOOR) ? TC_FLOOR : bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (por)                                  flag_q <= 1'b0;
    else if (fault)                           flag_q <= 1'b1;
    else if (wr_ctrl && !bus_wdata[CB_FLAG])  flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      rdata_q <= '0;
    end else if (rd_acc) begin
      unique case (bus_addr)
        REG_CTRL: rdata_q <= CNT_W'({armed_q, flag_q, mode_q, en_q});
        REG_TC:   rdata_q <= tc_q;
        REG_CNT:  rdata_q <= cnt;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
  assign rst_req   = rreq_q;
  assign irq       = irq_q;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
  parameter int CNT_W   = 32,
  parameter int MIN_TMO = 256
) (
  input logic             clk,
  input logic             por,
  input logic             rst,
  input logic             en_q,
  input logic             mode_q,
  input logic             armed_q,
  input logic             fault,
  input logic             rst_req,
  input logic             dbg_stall,
  input logic             feed_ok,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_q
);
  a_r3_en_clears_on_fault: assert property (@(posedge clk) disable iff (por || rst)
    $fell(en_q) |-> ($past(fault) || $past(rst) || $past(por)));

  a_r4_active_needs_en: assert property (@(posedge clk) disable iff (por || rst)
    armed_q |-> en_q);

  a_r2_tc_floor: assert property (@(posedge clk) disable iff (por || rst)
    tc_q >= CNT_W'(MIN_TMO));

  a_r7_mode_locked: assert property (@(posedge clk) disable iff (por || rst)
    en_q |=> $stable(mode_q));

  a_r9_rst_req_held: assert property (@(posedge clk) disable iff (por || rst)
    rst_req |=> rst_req);

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (por || rst)
    (dbg_stall && !feed_ok) |=> $stable(cnt));
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .MIN_TMO(MIN_TMO)) u_chk (
  .clk      (clk),
  .por      (por),
  .rst      (rst),
  .en_q     (en_q),
  .mode_q   (mode_q),
  .armed_q  (armed_q),
  .fault    (fault),
  .rst_req  (rst_req),
  .dbg_stall(dbg_stall),
  .feed_ok  (feed_ok),
  .cnt      (cnt),
  .tc_q     (tc_q)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
  localparam int CNT_W = 32;
  localparam int PRE   = 4;
  localparam int MINT  = 16;

  logic clk = 1'b0;
  logic por = 1'b1, rst = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [CNT_W-1:0] bus_wdata = '0;
  logic [CNT_W-1:0] bus_rdata;
  logic dbg_stall = 1'b0;
  logic rst_req, irq;
  int total = 0, bad = 0;
  logic [CNT_W-1:0] rd, rd2;

  always #10 clk = ~clk;

  wdt_guard #(.CNT_W(CNT_W), .PRESCALE(PRE), .MIN_TMO(MINT)) i_wdt_guard (
    .clk(clk), .por(por), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_stall(dbg_stall), .rst_req(rst_req), .irq(irq)
  );

  // {written value, expected read-back}
  localparam logic [63:0] TC_VEC [0:5] = '{
    {32'd0,          32'd16},
    {32'd15,         32'd16},
    {32'd16,         32'd16},
    {32'd17,         32'd17},
    {32'd1000,       32'd1000},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF}
  };

  task automatic chk(input string tag, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [CNT_W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic feed();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rst(input bit power);
    @(negedge clk);
    if (power) por = 1'b1; else rst = 1'b1;
    @(negedge clk);
    por = 1'b0; rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    por = 1'b0;
    // R11 reset state
    chk("R11 rst_req", {31'b0, rst_req}, 0);
    chk("R11 irq", {31'b0, irq}, 0);
    rdreg(2'd0, rd); chk("R11 ctrl", rd, 0);
    rdreg(2'd1, rd); chk("R11 tc", rd, MINT);
    rdreg(2'd3, rd); chk("R11 cnt", rd, MINT);

    // R2 clamp table
    for (int i = 0; i < 6; i++) begin
      wr(2'd1, TC_VEC[i][63:32]);
      rdreg(2'd1, rd);
      chk("R2 tc clamp", rd, TC_VEC[i][31:0]);
    end

    // R3 enable is set-only; R7 mode locked while enabled
    wr(2'd1, 32'd20);
    wr(2'd0, 32'h5);
    wr(2'd0, 32'h6);
    rdreg(2'd0, rd); chk("R3 R7 en set mode locked", rd, 32'h1);

    // R4 nothing moves before the first feed
    idle(200);
    chk("R4 no fault before feed", {31'b0, irq}, 0);
    rdreg(2'd3, rd); chk("R4 cnt frozen", rd, MINT);

    // R1 exact timeout, interrupt mode; R5 reload
    feed();
    rdreg(2'd3, rd); chk("R5 reload", rd, 20);
    rdreg(2'd0, rd); chk("R4 active bit", rd, 32'h9);
    idle(4 * 20 - 1 - 4);
    chk("R1 before edge", {31'b0, irq}, 0);
    idle(1);
    chk("R1 at edge irq", {31'b0, irq}, 1);
    chk("R7 no rst_req in irq mode", {31'b0, rst_req}, 0);
    rdreg(2'd0, rd); chk("R8 R3 flag set en clear", rd, 32'h4);
    wr(2'd0, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    rdreg(2'd0, rd); chk("R8 flag cleared", rd, 0);

    // R5 periodic feeding keeps it alive
    wr(2'd0, 32'h5);
    feed();
    for (int k = 0; k < 8; k++) begin
      idle(40);
      feed();
    end
    chk("R5 kept alive", {31'b0, irq}, 0);

    // R10 stall
    feed();
    dbg_stall = 1'b1;
    rdreg(2'd3, rd);
    idle(300);
    rdreg(2'd3, rd2);
    chk("R10 cnt held", rd2, rd);
    chk("R10 no fault in stall", {31'b0, irq}, 0);
    dbg_stall = 1'b0;
    idle(4 * 20 + 4);
    chk("R10 runs after stall", {31'b0, irq}, 1);
    wr(2'd0, 32'h0);

    // R6 key then read access
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hAA);
    rdreg(2'd1, rd);
    chk("R6 access after key1", {31'b0, irq}, 1);
    wr(2'd0, 32'h0);
    // R6 second key alone
    wr(2'd0, 32'h1);
    wr(2'd2, 32'h55);
    chk("R6 lone second key", {31'b0, irq}, 1);
    wr(2'd0, 32'h0);
    // R6 wrong second key
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'hAB);
    chk("R6 wrong second key", {31'b0, irq}, 1);
    wr(2'd0, 32'h0);
    // R6 disabled: bad writes ignored
    wr(2'd2, 32'h55);
    wr(2'd2, 32'h12);
    rdreg(2'd0, rd);
    chk("R6 ignored while disabled", {rd[30:0], irq}, 0);

    // R7 reset mode, R9 held, R8 survives rst
    wr(2'd0, 32'h2);
    wr(2'd0, 32'h3);
    feed();
    idle(4 * 20);
    chk("R7 rst_req raised", {31'b0, rst_req}, 1);
    chk("R7 no irq in reset mode", {31'b0, irq}, 0);
    idle(50);
    chk("R9 rst_req held", {31'b0, rst_req}, 1);
    pulse_rst(1'b0);
    chk("R9 rst clears rst_req", {31'b0, rst_req}, 0);
    rdreg(2'd0, rd); chk("R8 flag kept by rst", rd, 32'h4);
    pulse_rst(1'b1);
    rdreg(2'd0, rd); chk("R8 por clears flag", rd, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule